// File: doc/BRIEF.md
# Four-Channel Cascaded Periodic Timer

This block produces repeating time-outs on several independent channels. The count behind each channel has two stages. A small modulus down-counter, the micro time base, divides the bus clock and emits single-cycle enable ticks. A wider per-channel modulus down-counter advances only on those ticks. Two micro time bases are shared by all channels, and each channel picks one of them with its own select bit. The resulting period is the product of the two stage lengths.

Software controls the block through a flat register port with a write strobe, an address, write data and a combinational read-back. The port gives a global run bit, per-channel enables, per-channel micro time base selection, interrupt enables, reload values, a force-reload strobe register and sticky time-out flags that are cleared by writing 1. The force-reload register lets several channels restart from their reload values on the same cycle, which aligns their phases. Each channel drives a level interrupt and a one-cycle trigger pulse that other peripherals can use.

Register offsets: 0 run control (bit 0), 1 channel enables (bit i = channel i), 2 time base select (bit i = channel i; 0 selects time base 0, 1 selects time base 1), 3 force reload (write-only strobe; bit i reloads channel i, bit 8+k reloads time base k; reads 0), 4 interrupt enables (bit i), 5 time-out flags (bit i), 6 and 7 time base reload values, 8 to 11 channel reload values.

Top module: `pit_array`

## Requirements
- R1: After reset every register reads 0, and all interrupt and trigger outputs are 0.
- R2: With the run bit and a channel's enable set, and with time base reload value M and channel reload value N, the channel's trigger goes high m*n cycles after the write that sets the run bit, where m = M+1 and n = N+1.
- R3: A channel reloads its count by itself after each time-out and then times out again every m*n cycles.
- R4: A channel's select bit in register 2 chooses which time base clocks it: 0 picks time base 0 (offset 6), 1 picks time base 1 (offset 7).
- R5: A disabled channel produces no trigger and sets no flag. When it is enabled again it begins from its full reload value.
- R6: Each time-out raises the channel's trigger for exactly one cycle when m*n is greater than 1.
- R7: A time-out sets the channel's flag (register 5, bit i), which stays set. The channel's interrupt is high exactly while its flag and its interrupt-enable bit are both set.
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: A write to the force-reload register reloads the selected time bases and channels at that write's clock edge, so channels with equal periods then time out on the same cycle, m*n cycles after the write.
- R10: While the run bit is 0, all counters hold their reload values and no trigger or flag is produced.
- R11: Control, enable, select, interrupt-enable and reload registers read back the value that was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for addr |
| irq | output | NUM_CH | Per-channel interrupt level |
| trig | output | NUM_CH | Per-channel one-cycle time-out pulse |

## Verification
A register write takes effect at the clock edge that ends its write cycle. Counting cycles from the first cycle after that edge as cycle 0, a channel's trigger and flag are first high in cycle m*n, because one register stage sits between the last count and the output. The bench drives each write between edges, samples on the falling edge, and counts falling edges from the write until the pulse, both for the first time-out and for the gap to the next. The interrupt and read data are combinational on registered state, so they are checked in the same sampling slot where the flag is expected, and the absence of pulses on disabled or stopped channels is watched over a window of several periods.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // register offsets whose order the bench and software depend on
   localparam int unsigned A_CTRL    = 0;
   localparam int unsigned A_CHEN    = 1;
   localparam int unsigned A_MTSEL   = 2;
   localparam int unsigned A_FORCE   = 3;
   localparam int unsigned A_IRQEN   = 4;
   localparam int unsigned A_FLAGS   = 5;
   localparam int unsigned A_MT_BASE = 6;
   // bit position of the time base reload strobes inside the force register
   localparam int unsigned FORCE_MT_LSB = 8;

   function automatic int unsigned sel_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/pit_micro_timer.sv
module pit_micro_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         force_ld,
   input  logic [W-1:0] load,
   output logic         tick
);
   logic [W-1:0] cnt_q;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);
   assign tick    = run & ~force_ld & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (!run || force_ld || at_zero) cnt_q <= load;
      else                              cnt_q <= cnt_q - 1'b1;
   end

   // R10 / R9: a stopped or forced time base restarts from its reload value
   a_r10_base_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!run || force_ld) |=> cnt_q == $past(load));
endmodule

// File: rtl/pit_channel.sv
module pit_channel #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         force_ld,
   input  logic         tick,
   input  logic [W-1:0] load,
   output logic         timeout
);
   logic [W-1:0] cnt_q;
   logic         at_zero;

   assign at_zero = (cnt_q == '0);
   assign timeout = run & ~force_ld & tick & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || force_ld) cnt_q <= load;
      else if (tick)             cnt_q <= at_zero ? load : cnt_q - 1'b1;
   end

   // R9: a force strobe puts the full reload value in the counter
   a_r9_force_reload: assert property (@(posedge clk) disable iff (!rst_n)
      force_ld |=> cnt_q == $past(load));
   // R5: a disabled channel keeps its full reload value ready
   a_r5_disabled_full: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt_q == $past(load));
   // R3: between ticks the count does not move
   a_r3_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !force_ld && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
   import pit_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned NUM_MT = 2,
   parameter int unsigned MT_W   = 8,
   parameter int unsigned CH_W   = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4,
   localparam int unsigned SEL_W = sel_width(NUM_MT),
   localparam int unsigned CH_BASE = A_MT_BASE + NUM_MT
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                addr,
   input  logic [DATA_W-1:0]                wdata,
   output logic [DATA_W-1:0]                rdata,
   input  logic [NUM_CH-1:0]                timeout,
   output logic                             gen,
   output logic [NUM_CH-1:0]                ch_en,
   output logic [NUM_CH*SEL_W-1:0]          sel,
   output logic [NUM_CH-1:0]                irq_en,
   output logic [NUM_CH-1:0]                flags,
   output logic [NUM_CH-1:0]                force_ch,
   output logic [NUM_MT-1:0]                force_mt,
   output logic [NUM_MT-1:0][MT_W-1:0]      mt_load,
   output logic [NUM_CH-1:0][CH_W-1:0]      ch_load
);
   logic wr_ctrl, wr_chen, wr_sel, wr_force, wr_irqen, wr_flags;
   logic [NUM_CH-1:0] clr;

   assign wr_ctrl  = wr_en && addr == ADDR_W'(A_CTRL);
   assign wr_chen  = wr_en && addr == ADDR_W'(A_CHEN);
   assign wr_sel   = wr_en && addr == ADDR_W'(A_MTSEL);
   assign wr_force = wr_en && addr == ADDR_W'(A_FORCE);
   assign wr_irqen = wr_en && addr == ADDR_W'(A_IRQEN);
   assign wr_flags = wr_en && addr == ADDR_W'(A_FLAGS);

   assign force_ch = wr_force ? wdata[NUM_CH-1:0] : '0;
   assign force_mt = wr_force ? wdata[FORCE_MT_LSB +: NUM_MT] : '0;
   assign clr      = wr_flags ? wdata[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen    <= 1'b0;
         ch_en  <= '0;
         sel    <= '0;
         irq_en <= '0;
         flags  <= '0;
      end else begin
         if (wr_ctrl)  gen    <= wdata[0];
         if (wr_chen)  ch_en  <= wdata[NUM_CH-1:0];
         if (wr_sel)   sel    <= wdata[NUM_CH*SEL_W-1:0];
         if (wr_irqen) irq_en <= wdata[NUM_CH-1:0];
         // a new time-out wins over a clear in the same cycle
         flags <= (flags & ~clr) | timeout;
      end
   end

   generate
      for (genvar k = 0; k < NUM_MT; k++) begin : g_mt_ld
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mt_load[k] <= '0;
            else if (wr_en && addr == ADDR_W'(A_MT_BASE + k)) mt_load[k] <= wdata[MT_W-1:0];
         end
      end
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_ld
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ch_load[c] <= '0;
            else if (wr_en && addr == ADDR_W'(CH_BASE + c)) ch_load[c] <= wdata[CH_W-1:0];
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_CTRL))  rdata[0] = gen;
      if (addr == ADDR_W'(A_CHEN))  rdata[NUM_CH-1:0] = ch_en;
      if (addr == ADDR_W'(A_MTSEL)) rdata[NUM_CH*SEL_W-1:0] = sel;
      if (addr == ADDR_W'(A_IRQEN)) rdata[NUM_CH-1:0] = irq_en;
      if (addr == ADDR_W'(A_FLAGS)) rdata[NUM_CH-1:0] = flags;
      for (int k = 0; k < NUM_MT; k++)
         if (addr == ADDR_W'(A_MT_BASE + k)) rdata[MT_W-1:0] = mt_load[k];
      for (int c = 0; c < NUM_CH; c++)
         if (addr == ADDR_W'(CH_BASE + c)) rdata[CH_W-1:0] = ch_load[c];
   end

   // R7: flags never drop without a clear write
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_flag_chk
         a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[c] && !clr[c]) |=> flags[c]);
         a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[c] && !timeout[c]) |=> !flags[c]);
      end
   endgenerate
endmodule

// File: rtl/pit_array.sv
module pit_array
   import pit_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned NUM_MT = 2,
   parameter int unsigned MT_W   = 8,
   parameter int unsigned CH_W   = 16,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [NUM_CH-1:0] irq,
   output logic [NUM_CH-1:0] trig
);
   localparam int unsigned SEL_W   = sel_width(NUM_MT);
   localparam int unsigned PAD_N   = 1 << SEL_W;
   localparam int unsigned CH_BASE = A_MT_BASE + NUM_MT;

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 1 || NUM_CH > FORCE_MT_LSB) begin : g_bad_ch
         $error("pit_array: NUM_CH out of range");
      end
      if (NUM_MT < 1 || FORCE_MT_LSB + NUM_MT > DATA_W) begin : g_bad_mt
         $error("pit_array: NUM_MT does not fit the force register");
      end
      if (MT_W > DATA_W || CH_W > DATA_W || NUM_CH * SEL_W > DATA_W) begin : g_bad_w
         $error("pit_array: field wider than data port");
      end
      if (CH_BASE + NUM_CH > (1 << ADDR_W)) begin : g_bad_a
         $error("pit_array: register map exceeds address space");
      end
   endgenerate

   logic                        gen;
   logic [NUM_CH-1:0]           ch_en, irq_en, flags, force_ch, timeout;
   logic [NUM_CH*SEL_W-1:0]     sel;
   logic [NUM_MT-1:0]           force_mt, mt_tick;
   logic [NUM_MT-1:0][MT_W-1:0] mt_load;
   logic [NUM_CH-1:0][CH_W-1:0] ch_load;
   logic [PAD_N-1:0]            tick_pad;
   logic [NUM_CH-1:0]           trig_q;

   pit_regs #(
      .NUM_CH(NUM_CH), .NUM_MT(NUM_MT), .MT_W(MT_W), .CH_W(CH_W),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .timeout(timeout), .gen(gen), .ch_en(ch_en), .sel(sel),
      .irq_en(irq_en), .flags(flags), .force_ch(force_ch), .force_mt(force_mt),
      .mt_load(mt_load), .ch_load(ch_load)
   );

   generate
      for (genvar k = 0; k < NUM_MT; k++) begin : g_mt
         pit_micro_timer #(.W(MT_W)) u_mt (
            .clk(clk), .rst_n(rst_n), .run(gen), .force_ld(force_mt[k]),
            .load(mt_load[k]), .tick(mt_tick[k])
         );
      end
   endgenerate

   always_comb begin
      tick_pad = '0;
      tick_pad[NUM_MT-1:0] = mt_tick;
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic ch_tick;
         assign ch_tick = tick_pad[sel[c*SEL_W +: SEL_W]];
         pit_channel #(.W(CH_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .run(gen & ch_en[c]), .force_ld(force_ch[c]),
            .tick(ch_tick), .load(ch_load[c]), .timeout(timeout[c])
         );
         // R7: a trigger pulse is always accompanied by a set flag
         a_r7_flag_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
            trig_q[c] |-> flags[c]);
         // R5: only an enabled channel can pulse
         a_r5_trig_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            trig_q[c] |-> $past(ch_en[c]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= '0;
      else        trig_q <= timeout;
   end

   assign trig = trig_q;
   assign irq  = flags & irq_en;

   // R10: a stopped block emits no trigger in the following cycle
   a_r10_idle_no_trig: assert property (@(posedge clk) disable iff (!rst_n)
      !gen |=> trig_q == '0);
endmodule

// File: tb/pit_array_bench.sv
`timescale 1ns/1ps
module pit_array_bench;
   import pit_pkg::*;

   localparam int unsigned CHB = A_MT_BASE + 2;
   // vectors: channel, time base, base reload, channel reload, expected period
   localparam int unsigned VEC [5][5] = '{
      '{0, 0,   0, 0,   1},
      '{1, 1,   2, 3,  12},
      '{2, 0,   4, 1,  10},
      '{3, 1, 255, 0, 256},
      '{0, 1,   6, 5,  42}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [3:0]  irq, trig;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pit_array u_pit_array (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq(irq), .trig(trig)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int unsigned a, input int unsigned d);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'(a); wdata = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int unsigned a, output int unsigned d);
      @(negedge clk);
      addr = 4'(a);
      #1 d = rdata;
   endtask

   // counts falling edges until trig[ch] is seen
   task automatic wait_trig(input int ch, output int c);
      c = 0;
      while (!trig[ch] && c < 2000) begin
         @(negedge clk);
         c++;
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned d;
      int c;
      bit seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk(irq == 0 && trig == 0, "R1 outputs", int'({irq, trig}), 0);
      for (int a = 0; a < 12; a++) begin
         rd(a, d);
         chk(d == 0, "R1 register", int'(d), 0);
      end

      // R11: read-back
      wr(CHB + 2, 16'hBEEF);
      rd(CHB + 2, d); chk(d == 16'hBEEF, "R11 channel reload", int'(d), 16'hBEEF);
      wr(A_MT_BASE + 1, 8'hA5);
      rd(A_MT_BASE + 1, d); chk(d == 8'hA5, "R11 base reload", int'(d), 8'hA5);
      wr(A_MTSEL, 4'hA);
      rd(A_MTSEL, d); chk(d == 4'hA, "R11 select", int'(d), 4'hA);

      // R2 R3 R4 R6 R7: vector table
      for (int v = 0; v < 5; v++) begin
         int ch, per;
         ch = int'(VEC[v][0]);
         per = int'(VEC[v][4]);
         wr(A_CTRL, 0);
         wr(A_FLAGS, 4'hF);
         wr(A_MT_BASE + VEC[v][1], VEC[v][2]);
         wr(CHB + VEC[v][0], VEC[v][3]);
         wr(A_MTSEL, VEC[v][1] << VEC[v][0]);
         wr(A_CHEN, 1 << VEC[v][0]);
         wr(A_IRQEN, 1 << VEC[v][0]);
         wr(A_CTRL, 1);
         wait_trig(ch, c);
         chk(c == per, "R2 first time-out", c, per);
         chk(irq[ch] == 1'b1, "R7 interrupt on flag", int'(irq[ch]), 1);
         c = 0;
         do begin
            @(negedge clk);
            c++;
            if (c == 1 && per > 1) chk(trig[ch] == 1'b0, "R6 single-cycle pulse", int'(trig[ch]), 0);
         end while (!trig[ch] && c < 2000);
         chk(c == per, "R3 R4 reload period", c, per);
      end

      // R8 and R7: flag clear and interrupt gating
      wr(A_CTRL, 0);
      rd(A_FLAGS, d); chk(d[0] == 1'b1, "R7 flag sticky", int'(d), 1);
      wr(A_FLAGS, 0);
      rd(A_FLAGS, d); chk(d[0] == 1'b1, "R8 zero write keeps", int'(d), 1);
      wr(A_IRQEN, 0);
      chk(irq[0] == 1'b0, "R7 interrupt masked", int'(irq[0]), 0);
      wr(A_FLAGS, 1);
      rd(A_FLAGS, d); chk(d[0] == 1'b0, "R8 clear by one", int'(d), 0);

      // R10: stopped block
      wr(A_MT_BASE, 0); wr(CHB, 1); wr(A_MTSEL, 0); wr(A_CHEN, 1);
      wr(A_CTRL, 1);
      wait_trig(0, c);
      chk(c == 2, "R2 short period", c, 2);
      wr(A_CTRL, 0);
      wr(A_FLAGS, 4'hF);
      seen = 1'b0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (trig != 0) seen = 1'b1;
      end
      chk(!seen, "R10 no trigger while stopped", int'(seen), 0);
      rd(A_FLAGS, d); chk(d == 0, "R10 no flag while stopped", int'(d), 0);

      // R5: disabled channel and re-enable from full value
      wr(CHB, 4); wr(CHB + 1, 4); wr(A_CHEN, 1); wr(A_CTRL, 1);
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (trig[1]) seen = 1'b1;
      end
      chk(!seen, "R5 disabled channel silent", int'(seen), 0);
      rd(A_FLAGS, d); chk(d[1] == 1'b0, "R5 disabled channel no flag", int'(d), 0);
      wr(A_CHEN, 3);
      wait_trig(1, c);
      chk(c == 5, "R5 restart from full value", c, 5);

      // R9: alignment by force reload
      wr(A_CTRL, 0);
      wr(A_MT_BASE, 2); wr(CHB, 3); wr(CHB + 1, 3); wr(A_CHEN, 1);
      wr(A_CTRL, 1);
      repeat (7) @(negedge clk);
      wr(A_CHEN, 3);
      repeat (4) @(negedge clk);
      wr(A_FORCE, 16'h0103);
      wait_trig(0, c);
      chk(c == 12, "R9 forced restart period", c, 12);
      chk(trig[1] == 1'b1, "R9 channels aligned", int'(trig[1]), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule